// File: doc/BRIEF.md
# Inter-processor mailbox slot controller

This block lets the processors of a chip pass short messages to each other through a shared bank of mailbox slots. Each slot sits in a 16-word (0x40-byte) register window. To use a slot, a sender claims it by writing its own one-hot processor bit and reading the value back. It then marks one or more destination processors, fills the data words and writes the send register. The slot moves through a one-hot sequence of states: idle, outgoing, incoming and acknowledge. Each of these moves raises pending interrupt bits, first toward the destinations and then back toward the owner.

Each processor has one interrupt line. Per-processor status words gather the pending bit of every slot, in raw form and in masked form. A key-protected lock register decides whether slot registers accept writes at all. An acknowledge comes either from an explicit send write by the receiver or, in automatic mode, from the receiver clearing its interrupt. Once acknowledged, the slot returns to idle through a write to its owner register.

Access is through a word-addressed register bus. Writes take effect at the clock edge and reads are combinational. Byte offsets below equal word address times four.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the lock register (byte 0xA00) reads 1, every slot's mode register (slot byte 0x10) reads 0x10 (idle), every slot's mask register (slot byte 0x14) reads all ones, no bit is pending, and all interrupt lines are low.
- R2: Writing 0x1ACCE551 to the lock register unlocks it so that it reads 0. Writing any other value locks it again so that it reads 1.
- R3: While locked, writes to any slot register are ignored. Reads still work.
- R4: Writing a one-hot processor bit to the owner register (slot byte 0x00) of an idle, unowned slot makes that slot owned, and reading the register back returns that bit.
- R5: Writing the owner register of a slot already owned by another processor has no effect, so the owner value reads back unchanged.
- R6: A send write (slot byte 0x1C) to an idle, owned slot puts it in the outgoing state (mode bit 5) for exactly one cycle. The slot then enters the incoming state (mode bit 6), and the destination processors' pending bits become set.
- R7: Writing ones to the destination-set register (byte 0x04) adds destination bits, writing ones to the destination-clear register (byte 0x08) removes them, and the destination-status register (byte 0x0C) reads the result.
- R8: For processor c, the word at byte 0x804+8c holds bit s set when slot s has c's bit pending. The word at byte 0x800+8c holds the same bits with slots removed where c is masked (mask bit c set). The interrupt line of c is the OR of its masked word.
- R9: Writing ones to a slot's interrupt-clear register (byte 0x18) clears those processors' pending bits. Reading that register returns the pending bits not masked.
- R10: With mode bit 0 clear (manual acknowledge), a send write to a slot in the incoming state moves it to the acknowledge state (mode bit 7) and sets the owner's pending bit.
- R11: With mode bit 0 set (automatic acknowledge), an interrupt-clear write that leaves no destination bit pending, made while the slot is incoming, moves it to the acknowledge state and sets the owner's pending bit. No send write is needed.
- R12: Any owner-register write to a slot in the acknowledge state, or a write of the owner's own bit to an owned slot, returns the slot to idle. Owner, destinations, pending bits and data words all become zero, while the mode bit and the mask are kept.
- R13: Data words at slot bytes 0x20 and upward, at 4-byte stride, store and return full-width values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW (10) | Word address (byte offset divided by four) |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr |
| irq_o | output | NCPU (4) | One interrupt line per processor |

## Verification
The transient outgoing state is the hardest thing to observe, because it lasts a single cycle. The stimulus therefore reads the mode register on the cycle straight after the send write, and again one cycle later, to catch both the outgoing and incoming codes. The automatic acknowledge can only be reached by a chain of steps: claim, mode write, destination, mask, send, and then a clear that removes the last destination bit. The stimulus builds this chain on a second slot while the first slot is released. This shows that the slots keep their states apart.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

   typedef enum logic [3:0] {
      ST_IDLE = 4'b0001,
      ST_OUT  = 4'b0010,
      ST_IN   = 4'b0100,
      ST_ACK  = 4'b1000
   } slot_state_e;

   // register index inside a 16-word slot window
   localparam logic [3:0] RG_OWNER = 4'd0;
   localparam logic [3:0] RG_DSET  = 4'd1;
   localparam logic [3:0] RG_DCLR  = 4'd2;
   localparam logic [3:0] RG_DSTAT = 4'd3;
   localparam logic [3:0] RG_MODE  = 4'd4;
   localparam logic [3:0] RG_MASK  = 4'd5;
   localparam logic [3:0] RG_ICLR  = 4'd6;
   localparam logic [3:0] RG_SEND  = 4'd7;
   localparam int         RG_DATA0 = 8;

   localparam int SLOT_WSPAN   = 16;
   localparam int CPUST_WBASE  = 'h200;
   localparam int LOCK_WADDR   = 'h280;
   localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

endpackage

// File: rtl/ipc_mbox_keylock.sv
module ipc_mbox_keylock #(
   parameter int          DW  = 32,
   parameter logic [31:0] KEY = 32'h1ACC_E551
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic          locked_o
);

   logic locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  locked_q <= 1'b1;
      else if (we) locked_q <= (wdata != DW'(KEY));
   end

   assign locked_o = locked_q;

   AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata == DW'(KEY)) |=> !locked_o); // R2
   AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata != DW'(KEY)) |=> locked_o); // R2

endmodule

// File: rtl/ipc_mbox_slot.sv
module ipc_mbox_slot
   import ipc_mbox_pkg::*;
#(
   parameter int NCPU  = 4,
   parameter int NDATA = 2,
   parameter int DW    = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [3:0]      reg_sel,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   output logic [NCPU-1:0] pend_o,
   output logic [NCPU-1:0] mask_o
);

   slot_state_e                   state_q, state_d;
   logic [NCPU-1:0]               owner_q, owner_d;
   logic [NCPU-1:0]               dest_q, dest_d;
   logic [NCPU-1:0]               pend_q, pend_d;
   logic [NCPU-1:0]               mask_q, mask_d;
   logic                          auto_q, auto_d;
   logic [NDATA-1:0][DW-1:0]      data_q, data_d;

   logic [NCPU-1:0] wv;
   logic w_owner, w_dset, w_dclr, w_mode, w_mask, w_iclr, w_send;
   logic release_slot;

   assign wv      = wdata[NCPU-1:0];
   assign w_owner = wr_en && reg_sel == RG_OWNER;
   assign w_dset  = wr_en && reg_sel == RG_DSET;
   assign w_dclr  = wr_en && reg_sel == RG_DCLR;
   assign w_mode  = wr_en && reg_sel == RG_MODE;
   assign w_mask  = wr_en && reg_sel == RG_MASK;
   assign w_iclr  = wr_en && reg_sel == RG_ICLR;
   assign w_send  = wr_en && reg_sel == RG_SEND;

   always_comb begin
      state_d      = state_q;
      owner_d      = owner_q;
      dest_d       = dest_q;
      pend_d       = pend_q;
      mask_d       = mask_q;
      auto_d       = auto_q;
      data_d       = data_q;
      release_slot = 1'b0;

      if (w_dset) dest_d = dest_q | wv;
      if (w_dclr) dest_d = dest_q & ~wv;
      if (w_mask) mask_d = wv;
      if (w_mode) auto_d = wdata[0];
      for (int i = 0; i < NDATA; i++) begin
         if (wr_en && reg_sel == 4'(RG_DATA0 + i)) data_d[i] = wdata;
      end

      if (w_iclr) begin
         pend_d = pend_q & ~wv;
         if (state_q == ST_IN && auto_q && (pend_d & dest_q) == '0) begin
            state_d = ST_ACK;
            pend_d  = pend_d | owner_q;
         end
      end

      if (w_send) begin
         if (state_q == ST_IDLE && owner_q != '0) begin
            state_d = ST_OUT;
         end else if (state_q == ST_IN && !auto_q) begin
            state_d = ST_ACK;
            pend_d  = pend_d | owner_q;
         end
      end

      if (state_q == ST_OUT) begin
         state_d = ST_IN;
         pend_d  = pend_d | dest_q;
      end

      if (w_owner) begin
         if (state_q == ST_ACK || (owner_q != '0 && wv == owner_q))
            release_slot = 1'b1;
         else if (state_q == ST_IDLE && owner_q == '0 && $onehot(wv))
            owner_d = wv;
      end

      if (release_slot) begin
         state_d = ST_IDLE;
         owner_d = '0;
         dest_d  = '0;
         pend_d  = '0;
         data_d  = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         owner_q <= '0;
         dest_q  <= '0;
         pend_q  <= '0;
         mask_q  <= '1;
         auto_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         owner_q <= owner_d;
         dest_q  <= dest_d;
         pend_q  <= pend_d;
         mask_q  <= mask_d;
         auto_q  <= auto_d;
         data_q  <= data_d;
      end
   end

   always_comb begin
      rdata = '0;
      case (reg_sel)
         RG_OWNER: rdata[NCPU-1:0] = owner_q;
         RG_DSET,
         RG_DSTAT: rdata[NCPU-1:0] = dest_q;
         RG_MODE: begin
            rdata[7:4] = state_q;
            rdata[0]   = auto_q;
         end
         RG_MASK:  rdata[NCPU-1:0] = mask_q;
         RG_ICLR:  rdata[NCPU-1:0] = pend_q & ~mask_q;
         default: begin
            for (int i = 0; i < NDATA; i++) begin
               if (reg_sel == 4'(RG_DATA0 + i)) rdata = data_q[i];
            end
         end
      endcase
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;

   AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner_q)); // R4
   AST_OUT_LASTS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OUT && !w_owner) |=> state_q == ST_IN); // R6
   AST_ACK_FLAGS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK && $past(state_q) == ST_IN) |-> (pend_q & owner_q) != '0); // R10
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(data_q)); // R3

endmodule

// File: rtl/ipc_mbox_irqmap.sv
module ipc_mbox_irqmap #(
   parameter int NSLOT = 4,
   parameter int NCPU  = 4
) (
   input  logic [NSLOT-1:0][NCPU-1:0] pend_i,
   input  logic [NSLOT-1:0][NCPU-1:0] mask_i,
   output logic [NCPU-1:0][NSLOT-1:0] raw_o,
   output logic [NCPU-1:0][NSLOT-1:0] masked_o
);

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         assign raw_o[c][s]    = pend_i[s][c];
         assign masked_o[c][s] = pend_i[s][c] & ~mask_i[s][c];
      end
   end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbox_pkg::*;
#(
   parameter int NSLOT   = 4,
   parameter int NCPU    = 4,
   parameter int NDATA   = 2,
   parameter int DW      = 32,
   parameter int AW      = 10,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_we,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   output logic [NCPU-1:0] irq_o
);

   localparam int SLOT_WEND = NSLOT * SLOT_WSPAN;

   if (NSLOT < 1 || NSLOT > 32) begin : g_bad_nslot
      $error("NSLOT must be 1..32");
   end
   if (NCPU < 1 || NCPU >= DW) begin : g_bad_ncpu
      $error("NCPU must be 1..DW-1");
   end
   if (NDATA < 1 || NDATA > SLOT_WSPAN - RG_DATA0) begin : g_bad_ndata
      $error("NDATA must be 1..8");
   end
   if (AW < 10 || DW < 32) begin : g_bad_width
      $error("AW must be at least 10 and DW at least 32");
   end

   int                              addr_n;
   logic                            locked;
   logic                            lock_we;
   logic [NSLOT-1:0]                slot_we;
   logic [NSLOT-1:0][DW-1:0]        slot_rd;
   logic [NSLOT-1:0][NCPU-1:0]      pend;
   logic [NSLOT-1:0][NCPU-1:0]      mask;
   logic [NCPU-1:0][NSLOT-1:0]      raw;
   logic [NCPU-1:0][NSLOT-1:0]      masked;
   logic [NCPU-1:0]                 irq_d;

   assign addr_n  = int'(bus_addr);
   assign lock_we = bus_we && addr_n == LOCK_WADDR;

   ipc_mbox_keylock #(.DW(DW), .KEY(UNLOCK_KEY)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (lock_we),
      .wdata    (bus_wdata),
      .locked_o (locked)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slot_we[s] = bus_we && !locked &&
                          addr_n >= s * SLOT_WSPAN && addr_n < (s + 1) * SLOT_WSPAN;
      ipc_mbox_slot #(.NCPU(NCPU), .NDATA(NDATA), .DW(DW)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (slot_we[s]),
         .reg_sel (bus_addr[3:0]),
         .wdata   (bus_wdata),
         .rdata   (slot_rd[s]),
         .pend_o  (pend[s]),
         .mask_o  (mask[s])
      );
   end

   ipc_mbox_irqmap #(.NSLOT(NSLOT), .NCPU(NCPU)) u_irqmap (
      .pend_i   (pend),
      .mask_i   (mask),
      .raw_o    (raw),
      .masked_o (masked)
   );

   for (genvar c = 0; c < NCPU; c++) begin : g_irq
      assign irq_d[c] = |masked[c];
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= '0;
         else        irq_o <= irq_d;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_d;
   end

   always_comb begin
      bus_rdata = '0;
      if (addr_n < SLOT_WEND) begin
         for (int s = 0; s < NSLOT; s++) begin
            if (addr_n >= s * SLOT_WSPAN && addr_n < (s + 1) * SLOT_WSPAN)
               bus_rdata = slot_rd[s];
         end
      end else if (addr_n == LOCK_WADDR) begin
         bus_rdata[0] = locked;
      end else begin
         for (int c = 0; c < NCPU; c++) begin
            if (addr_n == CPUST_WBASE + 2 * c)     bus_rdata[NSLOT-1:0] = masked[c];
            if (addr_n == CPUST_WBASE + 2 * c + 1) bus_rdata[NSLOT-1:0] = raw[c];
         end
      end
   end

   AST_LOCKED_NO_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && bus_we) |-> slot_we == '0); // R3
   AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_we)); // R13

endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

   localparam int NSLOT = 4;
   localparam int NCPU  = 4;
   localparam int DW    = 32;
   localparam int AW    = 10;
   localparam int NV    = 56;

   // vector: {op[1:0], req[7:0], byte_addr[11:0], data[31:0]}
   // op 0 = write, 1 = read and compare, 2 = compare irq lines
   function automatic logic [53:0] op_wr(int rq, logic [11:0] a, logic [31:0] d);
      return {2'd0, 8'(rq), a, d};
   endfunction
   function automatic logic [53:0] op_rd(int rq, logic [11:0] a, logic [31:0] d);
      return {2'd1, 8'(rq), a, d};
   endfunction
   function automatic logic [53:0] op_irq(int rq, logic [31:0] d);
      return {2'd2, 8'(rq), 12'h000, d};
   endfunction

   localparam logic [53:0] VEC [NV] = '{
      op_rd (1,  12'hA00, 32'h1),            // R1 locked after reset
      op_rd (1,  12'h010, 32'h10),           // R1 idle
      op_rd (1,  12'h014, 32'hF),            // R1 all masked
      op_irq(1,  32'h0),                     // R1 no irq
      op_wr (3,  12'h020, 32'h55),           // R3 locked write
      op_rd (3,  12'h020, 32'h0),            // R3 ignored
      op_wr (2,  12'hA00, 32'h1ACCE551),     // R2 unlock
      op_rd (2,  12'hA00, 32'h0),            // R2
      op_wr (4,  12'h000, 32'h1),            // R4 cpu0 claims slot0
      op_rd (4,  12'h000, 32'h1),            // R4
      op_wr (5,  12'h000, 32'h2),            // R5 cpu1 tries
      op_rd (5,  12'h000, 32'h1),            // R5 unchanged
      op_wr (7,  12'h004, 32'h6),            // R7 set
      op_wr (7,  12'h008, 32'h4),            // R7 clear
      op_rd (7,  12'h00C, 32'h2),            // R7 status
      op_wr (8,  12'h014, 32'hC),            // R8 unmask cpu0/1
      op_wr (13, 12'h020, 32'hCAFE0001),     // R13
      op_wr (13, 12'h024, 32'h12345678),     // R13
      op_rd (13, 12'h024, 32'h12345678),     // R13
      op_rd (13, 12'h020, 32'hCAFE0001),     // R13
      op_wr (6,  12'h01C, 32'h1),            // R6 send
      op_rd (6,  12'h010, 32'h20),           // R6 outgoing
      op_rd (6,  12'h010, 32'h40),           // R6 incoming
      op_irq(8,  32'h2),                     // R8 cpu1 line
      op_rd (8,  12'h80C, 32'h1),            // R8 raw cpu1
      op_rd (8,  12'h808, 32'h1),            // R8 masked cpu1
      op_rd (9,  12'h018, 32'h2),            // R9 unmasked pending
      op_wr (9,  12'h018, 32'h2),            // R9 clear
      op_rd (9,  12'h80C, 32'h0),            // R9
      op_rd (6,  12'h010, 32'h40),           // R6 manual stays incoming
      op_wr (10, 12'h01C, 32'h2),            // R10 receiver acks
      op_rd (10, 12'h010, 32'h80),           // R10 ack state
      op_rd (10, 12'h800, 32'h1),            // R10 owner flagged
      op_wr (9,  12'h018, 32'h1),            // R9 clear ack
      op_wr (12, 12'h000, 32'h2),            // R12 release in ack
      op_rd (12, 12'h010, 32'h10),           // R12 idle
      op_rd (12, 12'h000, 32'h0),            // R12 owner gone
      op_rd (12, 12'h00C, 32'h0),            // R12 dest gone
      op_rd (12, 12'h020, 32'h0),            // R12 data gone
      op_wr (11, 12'h040, 32'h4),            // R11 cpu2 claims slot1
      op_wr (11, 12'h050, 32'h1),            // R11 auto mode
      op_wr (11, 12'h044, 32'h8),            // R11 dest cpu3
      op_wr (11, 12'h054, 32'h3),            // R11 unmask cpu2/3
      op_wr (11, 12'h05C, 32'h1),            // R11 send
      op_rd (11, 12'h050, 32'h21),           // R11 outgoing
      op_rd (11, 12'h050, 32'h41),           // R11 incoming
      op_rd (8,  12'h81C, 32'h2),            // R8 raw cpu3 slot1
      op_wr (11, 12'h058, 32'h8),            // R11 receiver clears
      op_rd (11, 12'h050, 32'h81),           // R11 ack with no send
      op_rd (11, 12'h810, 32'h2),            // R11 owner flagged
      op_irq(11, 32'h4),                     // R11 cpu2 line only
      op_wr (12, 12'h040, 32'h4),            // R12 release
      op_rd (12, 12'h050, 32'h11),           // R12 mode bit kept
      op_wr (2,  12'hA00, 32'h0),            // R2 relock
      op_rd (2,  12'hA00, 32'h1),            // R2
      op_wr (3,  12'h040, 32'h1)             // R3 claim while locked
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic            bus_we;
   logic [AW-1:0]   bus_addr;
   logic [DW-1:0]   bus_wdata;
   logic [DW-1:0]   bus_rdata;
   logic [NCPU-1:0] irq_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;

   ipc_mailbox #(.NSLOT(NSLOT), .NCPU(NCPU)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic check(int rq, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
   endtask

   task automatic rd(int rq, logic [11:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a[11:2];
      #1 check(rq, bus_rdata, exp);
   endtask

   task automatic irq_chk(int rq, logic [31:0] exp);
      @(negedge clk);
      bus_we = 1'b0;
      #1 check(rq, 32'(irq_o), exp);
   endtask

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [53:0] v;
         v = VEC[i];
         @(negedge clk);
         bus_we    = (v[53:52] == 2'd0);
         bus_addr  = v[43:34];
         bus_wdata = v[31:0];
         #1;
         if (v[53:52] == 2'd1) check(int'(v[51:44]), bus_rdata, v[31:0]);
         if (v[53:52] == 2'd2) check(int'(v[51:44]), 32'(irq_o), v[31:0]);
      end
      rd(3, 12'h040, 32'h0);                 // R3 locked claim ignored

      // R12: owner writes its own bit to an idle owned slot
      wr(12'hA00, 32'h1ACCE551);
      wr(12'h080, 32'h8);
      rd(4, 12'h080, 32'h8);                 // R4 cpu3 owns slot2
      wr(12'h0A4, 32'hDEADBEEF);
      wr(12'h080, 32'h8);
      rd(12, 12'h080, 32'h0);                // R12 released
      rd(12, 12'h0A4, 32'h0);                // R12 data cleared

      // R8: delivery to a masked processor keeps its line low
      wr(12'h0C0, 32'h1);
      wr(12'h0C4, 32'h2);
      wr(12'h0DC, 32'h1);
      @(negedge clk); bus_we = 1'b0;
      irq_chk(8, 32'h0);                     // R8 masked
      rd(8, 12'h80C, 32'h8);                 // R8 raw shows slot3
      rd(8, 12'h808, 32'h0);                 // R8 masked word empty
      wr(12'h0D4, 32'hD);                    // unmask cpu1 only
      irq_chk(8, 32'h2);                     // R8 line follows mask

      // R1: reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(1, 12'hA00, 32'h1);                 // R1
      rd(1, 12'h0D0, 32'h10);                // R1
      rd(1, 12'h80C, 32'h0);                 // R1
      irq_chk(1, 32'h0);                     // R1

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule